// File: doc/BRIEF.md
# Bus-to-Flit Request Bridge

This block sits at the edge of a chiplet and turns a simple memory-style bus into traffic on one narrow outgoing flit lane, then turns returning flits back into bus responses. Read requests and write requests arrive on their own valid/ready channels. Each accepted request is queued in a small per-channel FIFO. A control FSM takes requests from the queues and serializes them onto the lane in the lightweight packet format: a read becomes a single flit, and a write becomes a header flit that carries the address followed by a data flit.

When both queues hold work, the FSM alternates between reads and writes. A two-flit write always goes out as an unbroken pair. The outgoing flit is registered, so it stays fixed while the link applies backpressure. On the return side, a read-data flit fills a read response register. A write-acknowledge flit raises the write response. Any other flit is consumed and dropped.

Flit layout (FW bits): command in bits [FW-1:FW-3], mode bit at [FW-4] (0 = lightweight), payload in the low bits, zero-padded. Command codes: 1 read request, 2 write header, 3 write data, 4 read-data response, 5 write acknowledge.

Top module: `flitBridge`

## Requirements
- R1: After reset, txValid, rValid and bValid are low, and rdReqReady and wrReqReady are high.
- R2: An accepted read becomes exactly one flit with command 1 in bits [FW-1:FW-3], bit FW-4 at 0, and the address in the low AW bits with zeros above.
- R3: An accepted write becomes two flits on consecutive transfers with nothing between them: command 2 carrying the address, then command 3 carrying the data in the low DW bits.
- R4: When both queues hold requests, packets alternate between read and write, and each kind leaves in the order it was accepted.
- R5: While txValid is high and txReady is low, txValid stays high and txFlit does not change.
- R6: Each request queue holds 4 entries and its ready output is low while the queue is full. With the link stalled, a read channel accepts exactly 5 requests: four sit in the queue and one sits in the outgoing flit register.
- R7: An incoming flit with command 4 in lightweight mode sets rValid on the next edge, with rData equal to its low DW bits. rValid and rData hold until rReady is high.
- R8: While rValid is high, a further read-data flit is not accepted (rxReady low). It is taken once the pending response has been consumed.
- R9: bValid stays low after a write's flits have been sent. It rises only after a write-acknowledge flit (command 5) is received, and it holds until bReady.
- R10: An incoming flit with any other command, or with the mode bit set, is accepted and dropped, and it leaves rValid and bValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReqValid | input | 1 | Read request valid |
| rdReqReady | output | 1 | Read queue can accept |
| rdReqAddr | input | AW | Read address |
| wrReqValid | input | 1 | Write request valid |
| wrReqReady | output | 1 | Write queue can accept |
| wrReqAddr | input | AW | Write address |
| wrReqData | input | DW | Write data |
| rValid | output | 1 | Read response valid |
| rReady | input | 1 | Read response taken |
| rData | output | DW | Read response data |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response taken |
| txValid | output | 1 | Outgoing flit valid |
| txReady | input | 1 | Link accepts flit |
| txFlit | output | FW | Outgoing flit |
| rxValid | input | 1 | Incoming flit valid |
| rxReady | output | 1 | Incoming flit accepted |
| rxFlit | input | FW | Incoming flit |

## Verification
The bench builds the bridge with its default parameters: 32-bit address and data, a 40-bit flit and a queue depth of 4. At depth 4 the full-queue stall is reached after only five requests, so the ready deassertion and the in-order drain after it can both be observed directly. The 40-bit flit leaves four pad bits above the payload, so the zero-padding and the mode bit are both visible. Two requests of each kind pushed while the link is stalled are enough to show read/write alternation and to show that a write pair is never split.

// File: rtl/flitBridgePkg.sv
package flitBridgePkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_RD_REQ = 3'd1,
    CMD_WR_HDR = 3'd2,
    CMD_WR_DAT = 3'd3,
    CMD_RD_RSP = 3'd4,
    CMD_WR_ACK = 3'd5
  } flitCmdE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WHDR,
    ST_WDAT
  } txStateE;

  typedef struct packed {
    logic ldRd;
    logic ldWrHdr;
    logic ldWrDat;
  } ctrlStrobeT;
endpackage

// File: rtl/reqFifo.sv
module reqFifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == FULLCNT);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bridgeCtrl.sv
module bridgeCtrl
  import flitBridgePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdPending,
  input  logic       wrPending,
  input  logic       txReady,
  output logic       txValid,
  output ctrlStrobeT strobe
);
  txStateE state, nextState;
  logic    preferWr;
  logic    endOfPkt, slotFree, pickRd, pickWr;

  always_comb begin
    endOfPkt = ((state == ST_RD) || (state == ST_WDAT)) && txReady;
    slotFree = (state == ST_IDLE) || endOfPkt;
    pickRd   = slotFree && rdPending && (!wrPending || !preferWr);
    pickWr   = slotFree && wrPending && !pickRd;
    strobe.ldRd    = pickRd;
    strobe.ldWrHdr = pickWr;
    strobe.ldWrDat = (state == ST_WHDR) && txReady;
    if (pickRd)              nextState = ST_RD;
    else if (pickWr)         nextState = ST_WHDR;
    else if (strobe.ldWrDat) nextState = ST_WDAT;
    else if (endOfPkt)       nextState = ST_IDLE;
    else                     nextState = state;
  end

  assign txValid = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      preferWr <= 1'b0;
    end else begin
      state <= nextState;
      if (pickRd)      preferWr <= 1'b1;
      else if (pickWr) preferWr <= 1'b0;
    end
  end
endmodule

// File: rtl/bridgeData.sv
module bridgeData
  import flitBridgePkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int FW = 40
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobeT    strobe,
  input  logic [AW-1:0] rdHeadAddr,
  input  logic [AW-1:0] wrHeadAddr,
  input  logic [DW-1:0] wrHeadData,
  output logic [FW-1:0] txFlit,
  input  logic          rxValid,
  input  logic [FW-1:0] rxFlit,
  output logic          rxReady,
  output logic          rValid,
  input  logic          rReady,
  output logic [DW-1:0] rData,
  output logic          bValid,
  input  logic          bReady
);
  localparam int PLW = FW - 4;

  logic [PLW-1:0] payload;
  logic [2:0]     cmdBits;
  logic           loadAny;
  flitCmdE        rxCmd;
  logic           rxLite, isRsp, isAck, takeRsp, takeAck;

  always_comb begin
    payload = '0;
    cmdBits = CMD_NONE;
    if (strobe.ldRd) begin
      cmdBits           = CMD_RD_REQ;
      payload[AW-1:0]   = rdHeadAddr;
    end else if (strobe.ldWrHdr) begin
      cmdBits           = CMD_WR_HDR;
      payload[AW-1:0]   = wrHeadAddr;
    end else if (strobe.ldWrDat) begin
      cmdBits           = CMD_WR_DAT;
      payload[DW-1:0]   = wrHeadData;
    end
  end

  assign loadAny = strobe.ldRd || strobe.ldWrHdr || strobe.ldWrDat;

  always_ff @(posedge clk) begin
    if (!rstN) txFlit <= '0;
    else if (loadAny) txFlit <= {cmdBits, 1'b0, payload};
  end

  always_comb begin
    rxCmd  = flitCmdE'(rxFlit[FW-1 -: 3]);
    rxLite = !rxFlit[FW-4];
    isRsp  = rxLite && (rxCmd == CMD_RD_RSP);
    isAck  = rxLite && (rxCmd == CMD_WR_ACK);
    if (isRsp)      rxReady = !rValid;
    else if (isAck) rxReady = !bValid;
    else            rxReady = 1'b1;
    takeRsp = rxValid && isRsp && !rValid;
    takeAck = rxValid && isAck && !bValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValid <= 1'b0;
      rData  <= '0;
      bValid <= 1'b0;
    end else begin
      if (takeRsp) begin
        rValid <= 1'b1;
        rData  <= rxFlit[DW-1:0];
      end else if (rValid && rReady) begin
        rValid <= 1'b0;
      end
      if (takeAck)                bValid <= 1'b1;
      else if (bValid && bReady)  bValid <= 1'b0;
    end
  end
endmodule

// File: rtl/flitBridge.sv
module flitBridge
  import flitBridgePkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int FW    = 40,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdReqValid,
  output logic          rdReqReady,
  input  logic [AW-1:0] rdReqAddr,
  input  logic          wrReqValid,
  output logic          wrReqReady,
  input  logic [AW-1:0] wrReqAddr,
  input  logic [DW-1:0] wrReqData,
  output logic          rValid,
  input  logic          rReady,
  output logic [DW-1:0] rData,
  output logic          bValid,
  input  logic          bReady,
  output logic          txValid,
  input  logic          txReady,
  output logic [FW-1:0] txFlit,
  input  logic          rxValid,
  output logic          rxReady,
  input  logic [FW-1:0] rxFlit
);
  localparam int WRW = AW + DW;

  ctrlStrobeT     strobe;
  logic [AW-1:0]  rdHeadAddr;
  logic [WRW-1:0] wrHead;
  logic           rdEmpty, rdFull, wrEmpty, wrFull;

  reqFifo #(.W(AW), .DEPTH(DEPTH)) u_rdQ (
    .clk(clk), .rstN(rstN),
    .push(rdReqValid), .din(rdReqAddr),
    .pop(strobe.ldRd), .dout(rdHeadAddr),
    .empty(rdEmpty), .full(rdFull)
  );

  reqFifo #(.W(WRW), .DEPTH(DEPTH)) u_wrQ (
    .clk(clk), .rstN(rstN),
    .push(wrReqValid), .din({wrReqAddr, wrReqData}),
    .pop(strobe.ldWrDat), .dout(wrHead),
    .empty(wrEmpty), .full(wrFull)
  );

  assign rdReqReady = !rdFull;
  assign wrReqReady = !wrFull;

  bridgeCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rdPending(!rdEmpty), .wrPending(!wrEmpty),
    .txReady(txReady), .txValid(txValid),
    .strobe(strobe)
  );

  bridgeData #(.AW(AW), .DW(DW), .FW(FW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdHeadAddr(rdHeadAddr),
    .wrHeadAddr(wrHead[WRW-1 -: AW]),
    .wrHeadData(wrHead[DW-1:0]),
    .txFlit(txFlit),
    .rxValid(rxValid), .rxFlit(rxFlit), .rxReady(rxReady),
    .rValid(rValid), .rReady(rReady), .rData(rData),
    .bValid(bValid), .bReady(bReady)
  );
endmodule

// File: rtl/flitBridgeChk.sv
module flitBridgeChk #(
  parameter int FW = 40,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          txValid,
  input logic          txReady,
  input logic [FW-1:0] txFlit,
  input logic          rValid,
  input logic          rReady,
  input logic [DW-1:0] rData,
  input logic          bValid,
  input logic          bReady
);
  // R5
  flit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txFlit));

  // R3
  wr_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && (txFlit[FW-1 -: 3] == 3'd2) |=> txValid && (txFlit[FW-1 -: 3] == 3'd3));

  // R2
  lite_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !txFlit[FW-4]);

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid && $stable(rData));

  // R9
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid);
endmodule

bind flitBridge flitBridgeChk #(.FW(FW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN),
  .txValid(txValid), .txReady(txReady), .txFlit(txFlit),
  .rValid(rValid), .rReady(rReady), .rData(rData),
  .bValid(bValid), .bReady(bReady)
);

// File: tb/flitBridge_bench.sv
module flitBridge_bench;
  localparam int AW = 32, DW = 32, FW = 40, DEPTH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, rdReqValid, rdReqReady, wrReqValid, wrReqReady;
  logic [AW-1:0] rdReqAddr, wrReqAddr;
  logic [DW-1:0] wrReqData, rData;
  logic rValid, rReady, bValid, bReady, txValid, txReady, rxValid, rxReady;
  logic [FW-1:0] txFlit, rxFlit;

  flitBridge #(.AW(AW), .DW(DW), .FW(FW), .DEPTH(DEPTH)) u_flitBridge (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // {isWrite, address, data}
  localparam logic [64:0] VECS [6] = '{
    {1'b0, 32'h0000_1000, 32'h0},
    {1'b1, 32'h0000_2004, 32'hDEAD_BEEF},
    {1'b0, 32'hFFFF_FFFC, 32'h0},
    {1'b1, 32'h8000_0000, 32'h0000_0001},
    {1'b1, 32'h0000_0010, 32'hFFFF_FFFF},
    {1'b0, 32'h1234_5678, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [2:0] c, input logic [31:0] p);
    return {c, 1'b0, 4'h0, p};
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sendRd(input logic [AW-1:0] a);
    rdReqValid = 1; rdReqAddr = a;
    while (!rdReqReady) cyc();
    cyc(); rdReqValid = 0;
  endtask

  task automatic sendWr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wrReqValid = 1; wrReqAddr = a; wrReqData = d;
    while (!wrReqReady) cyc();
    cyc(); wrReqValid = 0;
  endtask

  task automatic recvFlit(output logic [FW-1:0] f);
    txReady = 1;
    while (!txValid) cyc();
    f = txFlit;
    cyc(); txReady = 0;
  endtask

  task automatic sendRx(input logic [FW-1:0] f);
    rxValid = 1; rxFlit = f;
    while (!rxReady) cyc();
    cyc(); rxValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] f, g;
    logic [FW-1:0] seq [6];
    int acc;
    rstN = 0; rdReqValid = 0; wrReqValid = 0; rdReqAddr = '0; wrReqAddr = '0; wrReqData = '0;
    rReady = 0; bReady = 0; txReady = 0; rxValid = 0; rxFlit = '0;
    repeat (4) cyc();
    rstN = 1;
    cyc();
    // R1 reset state
    chk(!txValid && !rValid && !bValid, "R1 valids", {txValid, rValid, bValid}, 0);
    chk(rdReqReady && wrReqReady, "R1 readies", {rdReqReady, wrReqReady}, 2'b11);

    // table walk: R2, R3, R7, R9
    foreach (VECS[i]) begin
      if (VECS[i][64]) begin
        sendWr(VECS[i][63:32], VECS[i][31:0]);
        recvFlit(f);
        chk(f == mk(3'd2, VECS[i][63:32]), "R3 header", 64'(f), 64'(mk(3'd2, VECS[i][63:32])));
        recvFlit(f);
        chk(f == mk(3'd3, VECS[i][31:0]), "R3 data", 64'(f), 64'(mk(3'd3, VECS[i][31:0])));
        chk(!bValid, "R9 no ack yet", 64'(bValid), 0);
        sendRx(mk(3'd5, 32'h0));
        chk(bValid, "R9 ack", 64'(bValid), 1);
        cyc();
        chk(bValid, "R9 hold", 64'(bValid), 1);
        bReady = 1; cyc(); bReady = 0;
        chk(!bValid, "R9 consumed", 64'(bValid), 0);
      end else begin
        sendRd(VECS[i][63:32]);
        recvFlit(f);
        chk(f == mk(3'd1, VECS[i][63:32]), "R2 read flit", 64'(f), 64'(mk(3'd1, VECS[i][63:32])));
        sendRx(mk(3'd4, ~VECS[i][63:32]));
        chk(rValid && rData == ~VECS[i][63:32], "R7 rdata", {31'h0, rValid, rData}, {31'h0, 1'b1, ~VECS[i][63:32]});
        rReady = 1; cyc(); rReady = 0;
        chk(!rValid, "R7 consumed", 64'(rValid), 0);
      end
    end

    // R5 hold under backpressure
    txReady = 0;
    sendRd(32'hABCD_0000);
    while (!txValid) cyc();
    f = txFlit;
    repeat (3) cyc();
    chk(txValid && txFlit == f, "R5 stable", 64'(txFlit), 64'(f));
    recvFlit(g);
    chk(g == mk(3'd1, 32'hABCD_0000), "R5 delivered", 64'(g), 64'(mk(3'd1, 32'hABCD_0000)));

    // R6 queue full
    acc = 0;
    rdReqValid = 1;
    for (int c = 0; c < 10; c++) begin
      rdReqAddr = 32'h100 + acc;
      if (rdReqReady) acc++;
      cyc();
    end
    rdReqValid = 0;
    chk(acc == DEPTH + 1, "R6 accepted", 64'(acc), 64'(DEPTH + 1));
    chk(!rdReqReady, "R6 ready low", 64'(rdReqReady), 0);
    for (int k = 0; k < DEPTH + 1; k++) begin
      recvFlit(f);
      chk(f == mk(3'd1, 32'h100 + k), "R6 drain order", 64'(f), 64'(mk(3'd1, 32'h100 + k)));
    end
    chk(rdReqReady, "R6 ready back", 64'(rdReqReady), 1);

    // R4 alternation
    rdReqValid = 1; rdReqAddr = 32'hA0; wrReqValid = 1; wrReqAddr = 32'hB0; wrReqData = 32'hC0;
    cyc();
    rdReqAddr = 32'hA1; wrReqAddr = 32'hB1; wrReqData = 32'hC1;
    cyc();
    rdReqValid = 0; wrReqValid = 0;
    for (int k = 0; k < 6; k++) recvFlit(seq[k]);
    if (seq[0][FW-1 -: 3] == 3'd1) begin
      g = mk(3'd1, 32'hA0); chk(seq[0] == g, "R4 p0", 64'(seq[0]), 64'(g));
      g = mk(3'd2, 32'hB0); chk(seq[1] == g, "R4 p1", 64'(seq[1]), 64'(g));
      g = mk(3'd3, 32'hC0); chk(seq[2] == g, "R4 p2", 64'(seq[2]), 64'(g));
      g = mk(3'd1, 32'hA1); chk(seq[3] == g, "R4 p3", 64'(seq[3]), 64'(g));
      g = mk(3'd2, 32'hB1); chk(seq[4] == g, "R4 p4", 64'(seq[4]), 64'(g));
      g = mk(3'd3, 32'hC1); chk(seq[5] == g, "R4 p5", 64'(seq[5]), 64'(g));
    end else begin
      g = mk(3'd2, 32'hB0); chk(seq[0] == g, "R4 p0", 64'(seq[0]), 64'(g));
      g = mk(3'd3, 32'hC0); chk(seq[1] == g, "R4 p1", 64'(seq[1]), 64'(g));
      g = mk(3'd1, 32'hA0); chk(seq[2] == g, "R4 p2", 64'(seq[2]), 64'(g));
      g = mk(3'd2, 32'hB1); chk(seq[3] == g, "R4 p3", 64'(seq[3]), 64'(g));
      g = mk(3'd3, 32'hC1); chk(seq[4] == g, "R4 p4", 64'(seq[4]), 64'(g));
      g = mk(3'd1, 32'hA1); chk(seq[5] == g, "R4 p5", 64'(seq[5]), 64'(g));
    end
    cyc();
    chk(!txValid, "R4 lane idle", 64'(txValid), 0);

    // R8 second response stalls
    sendRx(mk(3'd4, 32'h1111_1111));
    rxValid = 1; rxFlit = mk(3'd4, 32'h2222_2222);
    cyc(); cyc();
    chk(!rxReady, "R8 rxReady low", 64'(rxReady), 0);
    chk(rData == 32'h1111_1111, "R8 first kept", 64'(rData), 64'h1111_1111);
    rReady = 1; cyc(); rReady = 0;
    chk(rxReady, "R8 rxReady back", 64'(rxReady), 1);
    cyc(); rxValid = 0;
    chk(rValid && rData == 32'h2222_2222, "R8 second taken", 64'(rData), 64'h2222_2222);
    rReady = 1; cyc(); rReady = 0;

    // R10 other flits dropped
    sendRx(mk(3'd6, 32'h5555_5555));
    chk(!rValid && !bValid, "R10 unknown cmd", {rValid, bValid}, 0);
    sendRx({3'd4, 1'b1, 4'h0, 32'h7777_7777});
    chk(!rValid && !bValid, "R10 extended mode", {rValid, bValid}, 0);
    sendRx({3'd5, 1'b1, 36'h0});
    chk(!rValid && !bValid, "R10 extended ack", {rValid, bValid}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule